// File: doc/BRIEF.md
# Dual-State Keystream Feed-Forward and Stream XOR Stage

This block is the output end of a stream-cipher core that computes two 20-round cipher states at once. When the round engine finishes, it hands over both transformed states and the two matching initial states in one parallel load. For every one of the 32 words, the stage adds the transformed word to its initial word modulo 2^32 and keeps the resulting keystream. It then applies the keystream to an incoming 32-bit message stream and returns the ciphertext on an outgoing stream. Each port pair uses a valid/ready handshake.

The first keystream block covers the first message and the second block covers the second message, strictly in that order. Byte lane k of a data word carries byte k of the keystream word, so the least significant byte goes out first and the words follow in ascending index. A per-lane byte enable lets a short final word be handled: disabled lanes come out as zero. A last flag ends the current block early, and the keystream that was not used is dropped. Encryption and decryption are the same operation. A new pair of states is taken only after both blocks have been fully consumed.

Top module: `kxo_stream_xor`

## Requirements
- R1: After a load, keystream word w of state s equals (transformed word + initial word) mod 2^32. State s word w sits at bits [(s*WORDS+w)*32 +: 32] of each load bus.
- R2: Within a block the keystream words are applied in ascending index order starting at word 0. Byte lane k (bits [8k+7:8k]) of a data word uses byte k of the keystream word, least significant byte first.
- R3: For every enabled lane, ct_data equals msg_data XOR keystream. The standard 114-byte encryption vector (key bytes 00..1f, counter 1, nonce word1 = 0x4a000000) yields ciphertext words 0x9a352e6e and 0x80f96825 first.
- R4: Block 0 (ct_sel = 0) serves the first message and block 1 (ct_sel = 1) serves the second. Once the final block ends, the stage is idle again.
- R5: msg_keep bit k enables lane k, and a disabled lane outputs 0x00. ct_keep echoes msg_keep. A beat with msg_last, or the beat on word WORDS-1, ends its block. ct_last marks that beat, and the unused keystream of the block is discarded.
- R6: While busy, msg_ready follows ct_ready and ct_valid follows msg_valid. A stalled beat does not advance the keystream position.
- R7: load_ready is high only when idle. A load presented while busy is ignored and does not disturb the keystream in use.
- R8: After reset the stage is idle: load_ready = 1, ct_valid = 0 and msg_ready = 0.
- R9: Feeding the ciphertext back through a fresh load of the same states restores the plaintext on all enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | State pair offered |
| load_ready | output | 1 | Stage idle, pair accepted |
| load_round | input | NUM_STATES*WORDS*WORD_W | Transformed states, packed |
| load_init | input | NUM_STATES*WORDS*WORD_W | Initial states, packed |
| msg_valid | input | 1 | Message word present |
| msg_ready | output | 1 | Message word taken |
| msg_data | input | WORD_W | Message word |
| msg_keep | input | WORD_W/8 | Per-lane byte enable |
| msg_last | input | 1 | Final word of the current message |
| ct_valid | output | 1 | Ciphertext word present |
| ct_ready | input | 1 | Downstream accepts ciphertext |
| ct_data | output | WORD_W | Ciphertext word |
| ct_keep | output | WORD_W/8 | Echo of byte enables |
| ct_last | output | 1 | Final word of the current block |
| ct_sel | output | $clog2(NUM_STATES) | Block index of the current word |

## Verification
The bench builds two copies side by side with the default two states, sixteen 32-bit words per block and identical stimulus. One copy stores precomputed sums and the other adds at read time, so both feed-forward variants are compared on every beat. These defaults cover the full 114-byte standard vector, which spans exactly two blocks and ends in a two-byte partial word. They also cover a stall with a rejected load, an early end of block 0, and an implicit end at word 15 of block 1.

// File: rtl/kxo_pkg.sv
package kxo_pkg;
   localparam int BYTE_W = 8;

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/kxo_ks_bank.sv
module kxo_ks_bank #(
   parameter int NUM_STATES = 2,
   parameter int WORDS      = 16,
   parameter int WORD_W     = 32,
   parameter bit PRECOMPUTE = 1'b1,
   localparam int ADDR_W    = $clog2(NUM_STATES * WORDS),
   localparam int FLAT_W    = NUM_STATES * WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              load,
   input  logic [FLAT_W-1:0] round_flat,
   input  logic [FLAT_W-1:0] init_flat,
   input  logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] ks_word
);
   localparam int DEPTH = NUM_STATES * WORDS;

   if (PRECOMPUTE) begin : g_sum_at_load
      logic [WORD_W-1:0] sum_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (load) sum_q[i] <= round_flat[i*WORD_W +: WORD_W] + init_flat[i*WORD_W +: WORD_W];
         end
      end
      assign ks_word = sum_q[addr];
   end else begin : g_sum_at_read
      logic [WORD_W-1:0] rnd_q [DEPTH];
      logic [WORD_W-1:0] ini_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_word
         always_ff @(posedge clk) begin
            if (load) begin
               rnd_q[i] <= round_flat[i*WORD_W +: WORD_W];
               ini_q[i] <= init_flat[i*WORD_W +: WORD_W];
            end
         end
      end
      assign ks_word = rnd_q[addr] + ini_q[addr];
   end
endmodule

// File: rtl/kxo_seq.sv
module kxo_seq #(
   parameter int NUM_STATES = 2,
   parameter int WORDS      = 16,
   localparam int SEL_W     = $clog2(NUM_STATES),
   localparam int IDX_W     = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_fire,
   input  logic             beat_fire,
   input  logic             beat_last,
   output logic             busy,
   output logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] widx,
   output logic             blk_end
);
   localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_STATES - 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   assign blk_end = beat_last || (widx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sel  <= '0;
         widx <= '0;
      end else if (load_fire) begin
         busy <= 1'b1;
         sel  <= '0;
         widx <= '0;
      end else if (beat_fire) begin
         if (blk_end) begin
            widx <= '0;
            if (sel == LAST_SEL) begin
               busy <= 1'b0;
               sel  <= '0;
            end else begin
               sel <= sel + 1'b1;
            end
         end else begin
            widx <= widx + 1'b1;
         end
      end
   end

   AST_BLOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(sel) == LAST_SEL)); // R4
   AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_fire && !blk_end && !load_fire) |=> (widx == IDX_W'($past(widx) + 1'b1))); // R2
endmodule

// File: rtl/kxo_xor_lanes.sv
module kxo_xor_lanes #(
   parameter int WORD_W = 32,
   localparam int LANES = WORD_W / kxo_pkg::BYTE_W
) (
   input  logic [WORD_W-1:0] ks_word,
   input  logic [WORD_W-1:0] msg_word,
   input  logic [LANES-1:0]  keep,
   output logic [WORD_W-1:0] out_word
);
   localparam int BW = kxo_pkg::BYTE_W;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign out_word[b*BW +: BW] = keep[b] ? (msg_word[b*BW +: BW] ^ ks_word[b*BW +: BW]) : '0;
   end
endmodule

// File: rtl/kxo_stream_xor.sv
module kxo_stream_xor #(
   parameter int NUM_STATES = 2,
   parameter int WORDS      = 16,
   parameter int WORD_W     = 32,
   parameter bit PRECOMPUTE = 1'b1,
   localparam int SEL_W     = $clog2(NUM_STATES),
   localparam int IDX_W     = $clog2(WORDS),
   localparam int LANES     = WORD_W / kxo_pkg::BYTE_W,
   localparam int FLAT_W    = NUM_STATES * WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   output logic              load_ready,
   input  logic [FLAT_W-1:0] load_round,
   input  logic [FLAT_W-1:0] load_init,
   input  logic              msg_valid,
   output logic              msg_ready,
   input  logic [WORD_W-1:0] msg_data,
   input  logic [LANES-1:0]  msg_keep,
   input  logic              msg_last,
   output logic              ct_valid,
   input  logic              ct_ready,
   output logic [WORD_W-1:0] ct_data,
   output logic [LANES-1:0]  ct_keep,
   output logic              ct_last,
   output logic [SEL_W-1:0]  ct_sel
);
   if (WORD_W % kxo_pkg::BYTE_W != 0) begin : g_bad_width
      $error("WORD_W must be a whole number of bytes");
   end
   if (!kxo_pkg::is_pow2(WORDS)) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (!kxo_pkg::is_pow2(NUM_STATES)) begin : g_bad_states
      $error("NUM_STATES must be a power of two, at least 2");
   end

   logic             busy;
   logic             blk_end;
   logic             load_fire;
   logic             beat_fire;
   logic [SEL_W-1:0] sel;
   logic [IDX_W-1:0] widx;
   logic [WORD_W-1:0] ks_word;

   assign load_ready = !busy;
   assign load_fire  = load_valid && load_ready;
   assign ct_valid   = busy && msg_valid;
   assign msg_ready  = busy && ct_ready;
   assign beat_fire  = ct_valid && ct_ready;
   assign ct_keep    = msg_keep;
   assign ct_last    = blk_end;
   assign ct_sel     = sel;

   kxo_seq #(.NUM_STATES(NUM_STATES), .WORDS(WORDS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_fire (load_fire),
      .beat_fire (beat_fire),
      .beat_last (msg_last),
      .busy      (busy),
      .sel       (sel),
      .widx      (widx),
      .blk_end   (blk_end)
   );

   kxo_ks_bank #(
      .NUM_STATES (NUM_STATES),
      .WORDS      (WORDS),
      .WORD_W     (WORD_W),
      .PRECOMPUTE (PRECOMPUTE)
   ) u_bank (
      .clk        (clk),
      .load       (load_fire),
      .round_flat (load_round),
      .init_flat  (load_init),
      .addr       ({sel, widx}),
      .ks_word    (ks_word)
   );

   kxo_xor_lanes #(.WORD_W(WORD_W)) u_lanes (
      .ks_word  (ks_word),
      .msg_word (msg_data),
      .keep     (msg_keep),
      .out_word (ct_data)
   );

   AST_FEEDFORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> (ks_word == $past(load_round[WORD_W-1:0] + load_init[WORD_W-1:0]))); // R1
   AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ct_valid |-> !load_ready); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_valid && !ct_ready && !load_fire) |=> ($stable(ct_sel) && !load_ready)); // R6
endmodule

// File: tb/kxo_stream_xor_test.sv
`timescale 1ns/1ps
module kxo_stream_xor_test;
   localparam int NS = 2, NW = 16, WW = 32, FLAT = NS * NW * WW;
   localparam int PT_LEN = 114;
   localparam int BEATS  = 29;
   localparam logic [8*PT_LEN-1:0] PT =
      "Ladies and Gentlemen of the class of '99: If I could offer you only one tip for the future, sunscreen would be it.";
   // table of expected leading ciphertext words of the standard vector
   localparam logic [31:0] KNOWN_CT [2] = '{32'h9a352e6e, 32'h80f96825};

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_valid = 1'b0, load_ready;
   logic [FLAT-1:0] load_round = '0, load_init = '0;
   logic msg_valid = 1'b0, msg_ready, msg_last = 1'b0;
   logic [31:0] msg_data = '0;
   logic [3:0] msg_keep = '0;
   logic ct_valid, ct_ready = 1'b1, ct_last;
   logic [31:0] ct_data;
   logic [3:0] ct_keep;
   logic [0:0] ct_sel;
   logic load_ready_rd, msg_ready_rd, ct_valid_rd, ct_last_rd;
   logic [31:0] ct_data_rd;
   logic [3:0] ct_keep_rd;
   logic [0:0] ct_sel_rd;

   int total = 0, fails = 0;

   always #2 clk = ~clk;

   kxo_stream_xor #(.NUM_STATES(NS), .WORDS(NW), .WORD_W(WW), .PRECOMPUTE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
      .load_round(load_round), .load_init(load_init), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_data(msg_data), .msg_keep(msg_keep), .msg_last(msg_last),
      .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_data(ct_data), .ct_keep(ct_keep),
      .ct_last(ct_last), .ct_sel(ct_sel));

   kxo_stream_xor #(.NUM_STATES(NS), .WORDS(NW), .WORD_W(WW), .PRECOMPUTE(1'b0)) uut_rd (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready_rd),
      .load_round(load_round), .load_init(load_init), .msg_valid(msg_valid),
      .msg_ready(msg_ready_rd), .msg_data(msg_data), .msg_keep(msg_keep), .msg_last(msg_last),
      .ct_valid(ct_valid_rd), .ct_ready(ct_ready), .ct_data(ct_data_rd), .ct_keep(ct_keep_rd),
      .ct_last(ct_last_rd), .ct_sel(ct_sel_rd));

   // ---------------- reference cipher model ----------------
   function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   function automatic logic [127:0] qr(input logic [31:0] a, b, c, d);
      a = a + b; d = rotl(d ^ a, 16);
      c = c + d; b = rotl(b ^ c, 12);
      a = a + b; d = rotl(d ^ a, 8);
      c = c + d; b = rotl(b ^ c, 7);
      return {a, b, c, d};
   endfunction

   function automatic logic [511:0] rounds20(input logic [511:0] st);
      logic [31:0] x [16];
      logic [511:0] r;
      for (int i = 0; i < 16; i++) x[i] = st[i*32 +: 32];
      for (int k = 0; k < 10; k++) begin
         {x[0], x[4], x[8],  x[12]} = qr(x[0], x[4], x[8],  x[12]);
         {x[1], x[5], x[9],  x[13]} = qr(x[1], x[5], x[9],  x[13]);
         {x[2], x[6], x[10], x[14]} = qr(x[2], x[6], x[10], x[14]);
         {x[3], x[7], x[11], x[15]} = qr(x[3], x[7], x[11], x[15]);
         {x[0], x[5], x[10], x[15]} = qr(x[0], x[5], x[10], x[15]);
         {x[1], x[6], x[11], x[12]} = qr(x[1], x[6], x[11], x[12]);
         {x[2], x[7], x[8],  x[13]} = qr(x[2], x[7], x[8],  x[13]);
         {x[3], x[4], x[9],  x[14]} = qr(x[3], x[4], x[9],  x[14]);
      end
      for (int i = 0; i < 16; i++) r[i*32 +: 32] = x[i];
      return r;
   endfunction

   function automatic logic [511:0] init_state(input logic [31:0] ctr);
      logic [511:0] s;
      s[0*32 +: 32] = 32'h61707865; s[1*32 +: 32] = 32'h3320646e;
      s[2*32 +: 32] = 32'h79622d32; s[3*32 +: 32] = 32'h6b206574;
      for (int k = 0; k < 8; k++)
         s[(4+k)*32 +: 32] = {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)};
      s[12*32 +: 32] = ctr;
      s[13*32 +: 32] = 32'h0;
      s[14*32 +: 32] = 32'h4a000000;
      s[15*32 +: 32] = 32'h0;
      return s;
   endfunction

   function automatic logic [7:0] pt_byte(input int i);
      return PT[8*(PT_LEN-1-i) +: 8];
   endfunction

   // expected output per the lane rule: enabled lanes XOR, disabled lanes zero
   function automatic logic [31:0] expect_ct(input logic [31:0] d, k, input logic [3:0] keep);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = keep[b] ? (d[b*8 +: 8] ^ k[b*8 +: 8]) : 8'h00;
      return r;
   endfunction

   logic [511:0] init_a, init_b, rnd_a, rnd_b;
   logic [31:0] ks [2][16];
   logic [31:0] ctw [BEATS];
   logic [3:0]  keepw [BEATS];
   logic [31:0] ptw [BEATS];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_load();
      @(negedge clk);
      load_valid = 1'b1;
      load_round = {rnd_b, rnd_a};
      load_init  = {init_b, init_a};
      msg_valid  = 1'b0;
      #1;
      chk(load_ready === 1'b1, "R7", "load_ready when idle", 32'(load_ready), 32'd1);
      @(posedge clk);
      #1 load_valid = 1'b0;
   endtask

   task automatic beat(input int s, input int w, input logic [31:0] d, input logic [3:0] keep,
                       input logic last, input logic exp_last, input logic [31:0] exp,
                       output logic [31:0] got);
      @(negedge clk);
      msg_valid = 1'b1; msg_data = d; msg_keep = keep; msg_last = last; ct_ready = 1'b1;
      #1;
      chk(ct_valid === 1'b1 && msg_ready === 1'b1, "R6", "ct_valid/msg_ready on beat",
          {30'd0, ct_valid, msg_ready}, 32'd3);
      chk(ct_data === exp, "R2 R3", $sformatf("ct_data s%0d w%0d", s, w), ct_data, exp);
      chk(ct_data_rd === exp, "R1", $sformatf("read-time sum s%0d w%0d", s, w), ct_data_rd, exp);
      chk(ct_sel === 1'(s), "R4", "ct_sel", 32'(ct_sel), 32'(s));
      chk(ct_last === exp_last && ct_keep === keep, "R5", "ct_last/ct_keep",
          {27'd0, ct_last, ct_keep}, {27'd0, exp_last, keep});
      got = ct_data;
      @(posedge clk);
   endtask

   task automatic check_idle(input string req);
      @(negedge clk);
      msg_valid = 1'b1; msg_last = 1'b0; ct_ready = 1'b1;
      #1;
      chk(load_ready === 1'b1 && ct_valid === 1'b0 && msg_ready === 1'b0, req, "idle outputs",
          {29'd0, load_ready, ct_valid, msg_ready}, 32'd4);
      msg_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      total++; fails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [31:0] got;
      init_a = init_state(32'd1);
      init_b = init_state(32'd2);
      rnd_a  = rounds20(init_a);
      rnd_b  = rounds20(init_b);
      for (int w = 0; w < 16; w++) begin
         ks[0][w] = rnd_a[w*32 +: 32] + init_a[w*32 +: 32];
         ks[1][w] = rnd_b[w*32 +: 32] + init_b[w*32 +: 32];
      end
      for (int b = 0; b < BEATS; b++) begin
         for (int k = 0; k < 4; k++) begin
            keepw[b][k]       = (4*b + k) < PT_LEN;
            ptw[b][k*8 +: 8]  = keepw[b][k] ? pt_byte(4*b + k) : 8'hA5;
         end
      end

      // R8: reset state, with a message word offered during reset
      msg_valid = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk(load_ready === 1'b1 && ct_valid === 1'b0 && msg_ready === 1'b0, "R8", "in reset",
          {29'd0, load_ready, ct_valid, msg_ready}, 32'd4);
      @(negedge clk) rst_n = 1'b1;
      check_idle("R8");

      // Main walk: standard vector across both blocks, last word partial
      do_load();
      for (int b = 0; b < BEATS; b++) begin
         beat(b / 16, b % 16, ptw[b], keepw[b], b == BEATS - 1, (b == 15) || (b == BEATS - 1),
              expect_ct(ptw[b], ks[b / 16][b % 16], keepw[b]), got);
         ctw[b] = got;
      end
      for (int i = 0; i < 2; i++)
         chk(ctw[i] === KNOWN_CT[i], "R3", $sformatf("standard vector word %0d", i), ctw[i], KNOWN_CT[i]);
      chk(ctw[BEATS-1][31:16] === 16'h0, "R5", "masked lanes zero", ctw[BEATS-1], {16'h0, ctw[BEATS-1][15:0]});
      check_idle("R4");

      // R9: decrypt restores plaintext
      do_load();
      for (int b = 0; b < BEATS; b++) begin
         beat(b / 16, b % 16, ctw[b], keepw[b], b == BEATS - 1, (b == 15) || (b == BEATS - 1),
              expect_ct(ctw[b], ks[b / 16][b % 16], keepw[b]), got);
         for (int k = 0; k < 4; k++)
            if (keepw[b][k])
               chk(got[k*8 +: 8] === ptw[b][k*8 +: 8], "R9", $sformatf("plaintext byte %0d", 4*b + k),
                   32'(got[k*8 +: 8]), 32'(ptw[b][k*8 +: 8]));
      end
      check_idle("R4");

      // R6/R7: stall with a competing load, then resume at the held position
      do_load();
      @(negedge clk);
      msg_valid = 1'b1; msg_data = 32'h11223344; msg_keep = 4'hF; msg_last = 1'b0; ct_ready = 1'b0;
      load_valid = 1'b1; load_round = '0; load_init = '0;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk(ct_valid === 1'b1 && msg_ready === 1'b0 && load_ready === 1'b0, "R6 R7", "stalled beat",
             {29'd0, ct_valid, msg_ready, load_ready}, 32'd4);
         @(negedge clk);
      end
      load_valid = 1'b0;
      beat(0, 0, 32'h11223344, 4'hF, 1'b0, 1'b0, expect_ct(32'h11223344, ks[0][0], 4'hF), got);
      // R5: early end of block 0 discards words 2..15
      beat(0, 1, 32'hCAFEF00D, 4'b1001, 1'b1, 1'b1, expect_ct(32'hCAFEF00D, ks[0][1], 4'b1001), got);
      // block 1 runs to word 15 with no last flag
      for (int w = 0; w < 16; w++) begin
         logic [3:0] kp;
         kp = (w % 3 == 0) ? 4'b0101 : 4'hF;
         beat(1, w, 32'h01010101 * w, kp, 1'b0, w == 15, expect_ct(32'h01010101 * w, ks[1][w], kp), got);
      end
      check_idle("R4 R5");

      @(negedge clk);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule